// File: doc/BRIEF.md
# Prefix-Ordered Ternary Match Engine

This block is a register-built ternary lookup table used for longest-prefix match on the upper 64 bits of an IPv6 address. Every entry stores a key value, a prefix length, a prefix number and a valid bit. The prefix length selects how many leading key bits must agree with the stored value. The remaining low bits are don't-care. All entries are compared against the search key at once.

More than one entry can hit in the same search. The loader must place longer prefixes at lower indices. With that order, a lowest-index-first priority encoder picks the most specific prefix. The engine then returns that entry's prefix number.

A write port loads one entry per cycle. A lookup port accepts one key per cycle, and its result appears one cycle later. Keeping the table sorted is the loader's duty and is not done here.

Top module: `pfx_tcam_top`

## Requirements
- R1: An entry hits when its valid bit is set and the top L bits of the key equal the top L bits of its stored value. L is the stored prefix length, and all lower bits are ignored. L = 0 hits every key, and any length above 64 behaves as 64.
- R2: When several entries hit, the winner is the hitting entry with the lowest index.
- R3: On a hit, `rs_pfx_id` carries the prefix number stored with the winning entry, and `rs_nomatch` is 0.
- R4: A lookup presented with `lk_en` high in cycle t produces `rs_valid` high in cycle t+1. Lookups may be issued every cycle. In a cycle after `lk_en` was low, `rs_valid` is 0 and `rs_nomatch` and `rs_pfx_id` keep their previous values.
- R5: When no valid entry hits, `rs_nomatch` is 1 and `rs_pfx_id` is 0.
- R6: A write with `wr_en` high stores `wr_valid`, `wr_value`, `wr_len` and `wr_id` at index `wr_idx`, and lookups from the next cycle on see it. A lookup in the same cycle as the write sees the old contents. A write with `wr_valid` = 0 removes the entry from matching.
- R7: While `rst_n` is low, every entry is invalid, and `rs_valid`, `rs_nomatch` and `rs_pfx_id` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one table entry |
| wr_idx | input | 7 | Index of the entry written |
| wr_valid | input | 1 | Valid bit stored with the entry |
| wr_value | input | 64 | Stored key value |
| wr_len | input | 7 | Stored prefix length (0 to 64, larger treated as 64) |
| wr_id | input | 16 | Prefix number stored with the entry |
| lk_en | input | 1 | Lookup request |
| lk_key | input | 64 | Upper 64 bits of the address searched |
| rs_valid | output | 1 | Result strobe, one cycle after `lk_en` |
| rs_nomatch | output | 1 | No valid entry hit |
| rs_pfx_id | output | 16 | Prefix number of the winning entry, 0 on a miss |

## Verification
The assertions check several properties on every cycle. They check that the chosen entry is really hitting and that no lower index hits. They check that the grant is at most one-hot, that a miss always carries a zero prefix number, and that the result strobe trails the request by exactly one cycle while idle cycles hold the result. They also check that a written valid bit lands the next cycle and that no other cycle changes it. Other behaviours can only be shown by the bench's scenarios, which compare results against an independent table model. These are the bit-level masking rule, including length 0 and over-long lengths, the correct prefix number among overlapping prefixes, the old-contents view of a lookup that collides with a write, and the reset state.

// File: rtl/pfx_entry_store.sv
module pfx_entry_store #(
  parameter int N_ENT = 128,
  parameter int KEY_W = 64,
  parameter int ID_W  = 16,
  localparam int LEN_W = $clog2(KEY_W + 1),
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [ID_W-1:0]  wr_id,
  output logic [N_ENT-1:0] vld_o,
  output logic [KEY_W-1:0] val_o [N_ENT],
  output logic [LEN_W-1:0] len_o [N_ENT],
  output logic [ID_W-1:0]  id_o  [N_ENT]
);

  logic [N_ENT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      val_o[wr_idx] <= wr_value;
      len_o[wr_idx] <= wr_len;
      id_o[wr_idx]  <= wr_id;
    end
  end

  assign vld_o = vld_q;

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid))); // R6
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q)); // R6

endmodule

// File: rtl/pfx_match_row.sv
module pfx_match_row #(
  parameter int KEY_W = 64,
  localparam int LEN_W = $clog2(KEY_W + 1)
) (
  input  logic             vld,
  input  logic [KEY_W-1:0] value,
  input  logic [LEN_W-1:0] len,
  input  logic [KEY_W-1:0] key,
  output logic             hit
);

  // Care bits are the top 'len' positions; lengths past KEY_W saturate.
  function automatic logic [KEY_W-1:0] care_mask(input logic [LEN_W-1:0] l);
    logic [KEY_W-1:0] m;
    for (int b = 0; b < KEY_W; b++) m[b] = (b >= KEY_W - int'(l));
    return m;
  endfunction

  logic [KEY_W-1:0] diff_bits;
  assign diff_bits = (key ^ value) & care_mask(len);
  assign hit = vld && (diff_bits == '0);

endmodule

// File: rtl/pfx_prio_enc.sv
module pfx_prio_enc #(
  parameter int N_ENT = 128,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] hits,
  output logic             any_hit,
  output logic [IDX_W-1:0] win_idx,
  output logic [N_ENT-1:0] grant
);

  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hits[i]) begin
        win_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
    grant = '0;
    if (any_hit) grant[win_idx] = 1'b1;
  end

  AST_WIN_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hits[win_idx]); // R2
  AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hits & ((N_ENT'(1) << win_idx) - N_ENT'(1))) == '0)); // R2
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

endmodule

// File: rtl/pfx_tcam_top.sv
module pfx_tcam_top #(
  parameter int N_ENT = 128,
  parameter int KEY_W = 64,
  parameter int ID_W  = 16,
  localparam int LEN_W = $clog2(KEY_W + 1),
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [ID_W-1:0]  wr_id,
  input  logic             lk_en,
  input  logic [KEY_W-1:0] lk_key,
  output logic             rs_valid,
  output logic             rs_nomatch,
  output logic [ID_W-1:0]  rs_pfx_id
);

  logic [N_ENT-1:0] ent_vld;
  logic [KEY_W-1:0] ent_val [N_ENT];
  logic [LEN_W-1:0] ent_len [N_ENT];
  logic [ID_W-1:0]  ent_id  [N_ENT];
  logic [N_ENT-1:0] row_hit;
  logic [N_ENT-1:0] row_grant;
  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  pfx_entry_store #(.N_ENT(N_ENT), .KEY_W(KEY_W), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_value(wr_value), .wr_len(wr_len), .wr_id(wr_id),
    .vld_o(ent_vld), .val_o(ent_val), .len_o(ent_len), .id_o(ent_id)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_row
    pfx_match_row #(.KEY_W(KEY_W)) u_row (
      .vld(ent_vld[g]), .value(ent_val[g]), .len(ent_len[g]),
      .key(lk_key), .hit(row_hit[g])
    );
  end

  pfx_prio_enc #(.N_ENT(N_ENT)) u_prio (
    .clk(clk), .rst_n(rst_n), .hits(row_hit),
    .any_hit(any_hit), .win_idx(win_idx), .grant(row_grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid   <= 1'b0;
      rs_nomatch <= 1'b0;
      rs_pfx_id  <= '0;
    end else begin
      rs_valid <= lk_en;
      if (lk_en) begin
        rs_nomatch <= !any_hit;
        rs_pfx_id  <= any_hit ? ent_id[win_idx] : '0;
      end
    end
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rs_nomatch |-> (rs_pfx_id == '0)); // R5
  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> rs_valid); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> (!rs_valid && $stable(rs_pfx_id) && $stable(rs_nomatch))); // R4
  AST_GRANT_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_grant & ~row_hit) == '0)); // R2

endmodule

// File: tb/sim_pfx_tcam_top.sv
module sim_pfx_tcam_top;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, lk_en = 1'b0;
  logic [6:0]  wr_idx = '0, wr_len = '0;
  logic [63:0] wr_value = '0, lk_key = '0;
  logic [15:0] wr_id = '0;
  logic        rs_valid, rs_nomatch;
  logic [15:0] rs_pfx_id;

  always #2 clk = ~clk;

  pfx_tcam_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_value(wr_value), .wr_len(wr_len), .wr_id(wr_id), .lk_en(lk_en),
    .lk_key(lk_key), .rs_valid(rs_valid), .rs_nomatch(rs_nomatch), .rs_pfx_id(rs_pfx_id)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  bit          m_v   [N];
  logic [63:0] m_val [N];
  int          m_len [N];
  logic [15:0] m_id  [N];

  bit          pend_lk = 0;
  bit          exp_miss;
  logic [15:0] exp_id, last_id = '0;
  bit          last_miss = 0;
  string       exp_tag = "R4";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_lookup(input logic [63:0] k, output bit miss, output logic [15:0] id);
    miss = 1; id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_v[i]) begin
        int L = (m_len[i] > 64) ? 64 : m_len[i];
        if (L == 0 || (k >> (64 - L)) == (m_val[i] >> (64 - L))) begin
          miss = 0; id = m_id[i];
        end
      end
    end
  endfunction

  task automatic check_pending();
    if (pend_lk) begin
      chk(rs_valid == 1'b1, "R4", rs_valid, 1);
      chk(rs_nomatch == exp_miss, exp_miss ? "R5" : exp_tag, rs_nomatch, exp_miss);
      chk(rs_pfx_id == exp_id, exp_miss ? "R5" : exp_tag, rs_pfx_id, exp_id);
      last_id = exp_id; last_miss = exp_miss;
    end else begin
      chk(rs_valid == 1'b0, "R4", rs_valid, 0);
      chk(rs_pfx_id == last_id && rs_nomatch == last_miss, "R4", rs_pfx_id, last_id);
    end
  endtask

  task automatic step(input bit we, input int wi, input bit wv, input logic [63:0] wval,
                      input int wl, input int wid, input bit le, input logic [63:0] key,
                      input string tag);
    @(negedge clk);
    check_pending();
    wr_en = we; wr_idx = 7'(wi); wr_valid = wv; wr_value = wval;
    wr_len = 7'(wl); wr_id = 16'(wid);
    lk_en = le; lk_key = key;
    pend_lk = le;
    if (le) begin
      ref_lookup(key, exp_miss, exp_id);
      exp_tag = tag;
    end
    if (we) begin
      m_v[wi] = wv; m_val[wi] = wval; m_len[wi] = wl; m_id[wi] = 16'(wid);
    end
  endtask

  task automatic look(input logic [63:0] key, input string tag);
    step(0, 0, 0, '0, 0, 0, 1, key, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    logic [63:0] k;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_val[i] = '0; m_len[i] = 0; m_id[i] = '0;
    end
    // R7: reset state
    repeat (3) @(negedge clk);
    chk(rs_valid == 0, "R7", rs_valid, 0);
    chk(rs_nomatch == 0, "R7", rs_nomatch, 0);
    chk(rs_pfx_id == 0, "R7", rs_pfx_id, 0);
    rst_n = 1'b1;

    // R7/R5: empty table misses
    look(64'h1234_5678_9ABC_DEF0, "R7");
    // R6: write and lookup in the same cycle sees old (empty) contents
    step(1, 5, 1, 64'hABCD_0000_0000_0000, 16, 16'h55, 1, 64'hABCD_1234_0000_0001, "R6");
    look(64'hABCD_1234_0000_0001, "R1");
    look(64'hABCE_1234_0000_0001, "R1");
    // R2: overlapping prefixes, lower index wins
    step(1, 2, 1, 64'hABCD_0001_0000_0000, 32, 16'h22, 0, '0, "R2");
    look(64'hABCD_0001_FFFF_0000, "R2");
    look(64'hABCD_0002_FFFF_0000, "R3");
    // R1: length zero is a default route
    step(1, 127, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 16'h7F, 1, 64'h0, "R1");
    look(64'h0, "R1");
    // R1: length above 64 acts as exact match
    step(1, 0, 1, 64'h0123_4567_89AB_CDEF, 70, 16'h11, 0, '0, "R1");
    look(64'h0123_4567_89AB_CDEF, "R1");
    look(64'h0123_4567_89AB_CDEE, "R1");
    // R6: invalidating an entry removes it
    step(1, 2, 0, 64'hABCD_0001_0000_0000, 32, 16'h22, 0, '0, "R6");
    look(64'hABCD_0001_FFFF_0000, "R6");
    // R4: idle hold, then back-to-back
    step(0, 0, 0, '0, 0, 0, 0, '0, "R4");
    look(64'h0123_4567_89AB_CDEF, "R4");
    look(64'hABCD_0000_0000_0000, "R4");

    // Random fill, prefix lengths non-increasing with index
    for (int i = 0; i < N - 1; i++) begin
      logic [63:0] v = {$urandom, $urandom};
      step(1, i, ($urandom % 10) != 0, v, 64 - i / 2, 16'h100 + i, 0, '0, "R6");
    end
    for (int t = 0; t < 4000; t++) begin
      int j = $urandom % (N - 1);
      int sh = $urandom % 65;
      k = m_val[j];
      if (sh > 0) k = k ^ (64'({$urandom, $urandom}) & ((sh == 64) ? '1 : ((64'd1 << sh) - 64'd1)));
      if (($urandom % 8) == 0) k = {$urandom, $urandom};
      if (($urandom % 16) == 0)
        step(1, j, ($urandom % 4) != 0, {$urandom, $urandom}, m_len[j], 16'h200 + t % 256,
             ($urandom % 4) != 0, k, "R6");
      else
        step(0, 0, 0, '0, 0, 0, ($urandom % 6) != 0, k, "R3");
    end
    step(0, 0, 0, '0, 0, 0, 0, '0, "R4");
    @(negedge clk);
    check_pending();
    finish_run();
  end
endmodule